// File: doc/BRIEF.md
# Weight Readout Address Generator

This block produces the read sequence for convolution weights held in a weight SRAM that feeds a systolic array. Weights sit in memory flattened so that the output-channel index changes fastest, which lets one SRAM word carry a weight for every array column at once. The generator walks that memory with three nested loop counters. The outer tiling counter picks the group of output channels for a compute context. The middle counter walks the kernel and input-channel positions of that context in memory order. The inner auxiliary counter covers a batch of weights that straddles two adjacent SRAM words when the data is misaligned.

Each counter adds its own preset step and wraps to zero once its next value would reach its preset limit. The global element index is the plain sum of the three counts, so no multiplier is needed. The index is then split into an SRAM word address (the upper bits) and an element offset inside that word (the lower bits). A start pulse captures the six step and limit values and begins a run. A stall input freezes the walk while the consumer cannot accept a beat. A one-cycle done pulse closes the run.

Top module: `wt_fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rd_valid` and `done` are low after that edge.
- R2: A `start` sampled while `rd_valid` is low begins a run: `rd_valid` is high after that edge and the first beat has index 0 (address 0, offset 0).
- R3: Beats follow the nest with auxiliary innermost, then sequential, then tiling outermost. Each counter advances by its step when the level below it wraps, or on every accepted beat for the auxiliary level. It returns to 0 when its next value is greater than or equal to its limit. The beat index is aux + seq + til.
- R4: For each beat, `rd_addr` equals index divided by ELEMS_PER_WORD (8 by default) and `rd_off` equals index modulo ELEMS_PER_WORD.
- R5: When the auxiliary limit equals the auxiliary step, exactly one beat is issued per step of the sequential counter.
- R6: A beat is accepted only on an edge where `rd_valid` is high and `stall` is low. While `stall` is high, `rd_valid`, `rd_addr` and `rd_off` hold.
- R7: `done` is high for exactly one cycle, in the cycle after the final beat is accepted, with `rd_valid` low in that cycle.
- R8: A `start` during a run is ignored and the run continues unchanged.
- R9: Changes on the configuration inputs during a run have no effect on the sequence.
- R10: With `stall` held low, one beat is accepted on every cycle of a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| stall | input | 1 | Consumer cannot take the current beat |
| cfg_til_step | input | IDX_W | Tiling counter step |
| cfg_til_lim | input | IDX_W | Tiling counter limit |
| cfg_seq_step | input | IDX_W | Sequential counter step |
| cfg_seq_lim | input | IDX_W | Sequential counter limit |
| cfg_aux_step | input | IDX_W | Auxiliary counter step |
| cfg_aux_lim | input | IDX_W | Auxiliary counter limit |
| rd_valid | output | 1 | Current beat is valid |
| rd_addr | output | IDX_W-log2(ELEMS_PER_WORD) | SRAM word address of the beat |
| rd_off | output | log2(ELEMS_PER_WORD) | Element offset inside the word |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The hardest case to reach is a carry that ripples through all three levels while the consumer stalls. That same edge ends the run, and it must still leave the counters and the done pulse right. To get there, the stimulus runs misaligned configurations in which the auxiliary loop iterates twice. It applies stall patterns that are high on alternating cycles and on every third cycle, so stalls land on both inner and full wraps. One run also pulses start and scrambles every configuration input partway through, and the expected sequence must still come out unchanged.

// File: rtl/wfs_pkg.sv
// Shared types for the weight readout sequencer.
// Assumes: three loop levels, ordered innermost first.
package wfs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } wfs_state_e;

    localparam int LVL_N   = 3;
    localparam int LVL_AUX = 0;
    localparam int LVL_SEQ = 1;
    localparam int LVL_TIL = 2;
endpackage

// File: rtl/wfs_loop_counter.sv
// One loop level: adds STEP on each advance and returns to zero once the
// next value would reach LIMIT. Reports the wrap so the outer level can move.
// Assumes: step is nonzero; values stay within W bits.
module wfs_loop_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         advance,
    input  logic [W-1:0] step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W:0] next_val;

    // Candidate next value, one bit wider so it cannot overflow.
    always_comb begin
        next_val = {1'b0, count} + {1'b0, step};
        wrap     = advance && (next_val >= {1'b0, limit});
    end

    // Count register: clear on a new run, step or wrap on advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (advance) begin
            count <= wrap ? '0 : next_val[W-1:0];
        end
    end
endmodule

// File: rtl/wfs_run_ctrl.sv
// Run control: starts a run from idle, accepts beats when not stalled,
// returns to idle after the final beat and pulses done once.
// Assumes: last_wrap is only high on an accepted beat.
module wfs_run_ctrl
    import wfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stall,
    input  logic last_wrap,
    output logic running,
    output logic load,
    output logic accept,
    output logic done
);
    wfs_state_e state;

    // Handshake decode from the current state.
    always_comb begin
        running = (state == ST_RUN);
        load    = (state == ST_IDLE) && start;
        accept  = running && !stall;
    end

    // State register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            done  <= 1'b0;
        end else begin
            done <= accept && last_wrap;
            if (load) begin
                state <= ST_RUN;
            end else if (accept && last_wrap) begin
                state <= ST_IDLE;
            end
        end
    end
endmodule

// File: rtl/wfs_index_split.sv
// Sums the level counts into a global element index and splits it into a
// word address and an in-word offset.
// Assumes: ELEMS_PER_WORD is a power of two, at least 2; the sum fits IDX_W.
module wfs_index_split #(
    parameter int IDX_W          = 16,
    parameter int ELEMS_PER_WORD = 8,
    parameter int N              = 3,
    localparam int OFF_W         = $clog2(ELEMS_PER_WORD),
    localparam int ADDR_W        = IDX_W - OFF_W
) (
    input  logic [IDX_W-1:0]  counts [N],
    output logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off
);
    logic [IDX_W-1:0] idx;

    // Multiplier-free index: plain sum of the counts, then a bit split.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            idx = idx + counts[i];
        end
        addr = idx[IDX_W-1:OFF_W];
        off  = idx[OFF_W-1:0];
    end
endmodule

// File: rtl/wt_fetch_seq.sv
// Weight readout sequencer top. Captures step/limit settings on start,
// walks three nested counters (aux innermost, tiling outermost) and
// presents one word address and offset per beat.
// Assumes: steps nonzero; settings are shadowed so inputs may move mid-run.
module wt_fetch_seq
    import wfs_pkg::*;
#(
    parameter int IDX_W          = 16,
    parameter int ELEMS_PER_WORD = 8,
    localparam int OFF_W         = $clog2(ELEMS_PER_WORD),
    localparam int ADDR_W        = IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stall,
    input  logic [IDX_W-1:0]  cfg_til_step,
    input  logic [IDX_W-1:0]  cfg_til_lim,
    input  logic [IDX_W-1:0]  cfg_seq_step,
    input  logic [IDX_W-1:0]  cfg_seq_lim,
    input  logic [IDX_W-1:0]  cfg_aux_step,
    input  logic [IDX_W-1:0]  cfg_aux_lim,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [OFF_W-1:0]  rd_off,
    output logic              done
);
    logic [IDX_W-1:0] in_step [LVL_N];
    logic [IDX_W-1:0] in_lim  [LVL_N];
    logic [IDX_W-1:0] sh_step [LVL_N];
    logic [IDX_W-1:0] sh_lim  [LVL_N];
    logic [IDX_W-1:0] cnt     [LVL_N];
    logic             adv     [LVL_N];
    logic             wrp     [LVL_N];
    logic             running;
    logic             load;
    logic             accept;

    // Gather the port settings into level-indexed arrays.
    always_comb begin
        in_step[LVL_AUX] = cfg_aux_step;
        in_lim[LVL_AUX]  = cfg_aux_lim;
        in_step[LVL_SEQ] = cfg_seq_step;
        in_lim[LVL_SEQ]  = cfg_seq_lim;
        in_step[LVL_TIL] = cfg_til_step;
        in_lim[LVL_TIL]  = cfg_til_lim;
    end

    wfs_run_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stall     (stall),
        .last_wrap (wrp[LVL_N-1]),
        .running   (running),
        .load      (load),
        .accept    (accept),
        .done      (done)
    );

    for (genvar g = 0; g < LVL_N; g++) begin : g_lvl
        // Shadow copy of this level's settings, taken at run start.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_step[g] <= '0;
                sh_lim[g]  <= '0;
            end else if (load) begin
                sh_step[g] <= in_step[g];
                sh_lim[g]  <= in_lim[g];
            end
        end

        if (g == 0) begin : g_inner
            assign adv[g] = accept;
        end else begin : g_outer
            assign adv[g] = wrp[g-1];
        end

        wfs_loop_counter #(.W(IDX_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (load),
            .advance (adv[g]),
            .step    (sh_step[g]),
            .limit   (sh_lim[g]),
            .count   (cnt[g]),
            .wrap    (wrp[g])
        );
    end

    wfs_index_split #(
        .IDX_W          (IDX_W),
        .ELEMS_PER_WORD (ELEMS_PER_WORD),
        .N              (LVL_N)
    ) u_split (
        .counts (cnt),
        .addr   (rd_addr),
        .off    (rd_off)
    );

    assign rd_valid = running;
endmodule

// File: rtl/wt_fetch_seq_chk.sv
// Port-level protocol checks for the weight readout sequencer, bound to
// every instance of the top module.
module wt_fetch_seq_chk #(
    parameter int ADDR_W = 13,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              stall,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [OFF_W-1:0]  rd_off,
    input logic              done
);
    // R1: reset leaves no beat and no done pulse.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !rd_valid && !done);

    // R2: start from idle opens a run at index zero.
    a_r2_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid && start |=> rd_valid && rd_addr == '0 && rd_off == '0);

    // R6: a stalled beat is held unchanged.
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && stall |=> rd_valid && $stable(rd_addr) && $stable(rd_off));

    // R7: done lasts one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: done follows a valid beat and is never alongside one.
    a_r7_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_valid && $past(rd_valid));

    // R8: start during a stalled run does not end or restart it.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && stall && start |=> rd_valid && !done);
endmodule

bind wt_fetch_seq wt_fetch_seq_chk #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .stall    (stall),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_off   (rd_off),
    .done     (done)
);

// File: tb/wt_fetch_seq_test.sv
module wt_fetch_seq_test;
    localparam int IDX_W  = 16;
    localparam int EPW    = 8;
    localparam int OFF_W  = 3;
    localparam int ADDR_W = IDX_W - OFF_W;
    localparam int NV     = 4;
    localparam int WDOG   = 100000;

    // Columns: til_step, til_lim, seq_step, seq_lim, aux_step, aux_lim.
    localparam logic [15:0] VEC [NV][6] = '{
        '{16'd8, 16'd16, 16'd16, 16'd64, 16'd8, 16'd8 },
        '{16'd6, 16'd12, 16'd12, 16'd36, 16'd8, 16'd16},
        '{16'd4, 16'd4,  16'd5,  16'd20, 16'd8, 16'd8 },
        '{16'd3, 16'd9,  16'd9,  16'd27, 16'd8, 16'd16}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic stall = 1'b0;
    logic [IDX_W-1:0] cfg_til_step = '0, cfg_til_lim = '0;
    logic [IDX_W-1:0] cfg_seq_step = '0, cfg_seq_lim = '0;
    logic [IDX_W-1:0] cfg_aux_step = '0, cfg_aux_lim = '0;
    logic rd_valid;
    logic [ADDR_W-1:0] rd_addr;
    logic [OFF_W-1:0] rd_off;
    logic done;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    bit ended = 0;
    int expv [0:255];
    int nexp;

    always #5 clk = ~clk;

    wt_fetch_seq #(.IDX_W(IDX_W), .ELEMS_PER_WORD(EPW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .stall(stall),
        .cfg_til_step(cfg_til_step), .cfg_til_lim(cfg_til_lim),
        .cfg_seq_step(cfg_seq_step), .cfg_seq_lim(cfg_seq_lim),
        .cfg_aux_step(cfg_aux_step), .cfg_aux_lim(cfg_aux_lim),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_off(rd_off), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
            finish_run();
        end
    end

    // Independent model of the nested walk (R3).
    task automatic build_exp(input int v);
        nexp = 0;
        for (int t = 0; t < int'(VEC[v][1]); t += int'(VEC[v][0]))
            for (int s = 0; s < int'(VEC[v][3]); s += int'(VEC[v][2]))
                for (int a = 0; a < int'(VEC[v][5]); a += int'(VEC[v][4])) begin
                    expv[nexp] = t + s + a;
                    nexp++;
                end
    endtask

    function automatic bit stall_at(input int mode, input int c);
        case (mode)
            1: return c[0];
            3: return (c % 3) == 0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_vec(input int v, input bit inject);
        int k = 0;
        int c = 0;
        int beat_cycles = 0;
        bit fin = 0;
        bit injected = 0;
        bit prev_hold = 0;
        int p_addr = 0, p_off = 0;
        build_exp(v);
        @(negedge clk);
        cfg_til_step = VEC[v][0]; cfg_til_lim = VEC[v][1];
        cfg_seq_step = VEC[v][2]; cfg_seq_lim = VEC[v][3];
        cfg_aux_step = VEC[v][4]; cfg_aux_lim = VEC[v][5];
        start = 1'b1;
        stall = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(rd_valid && rd_addr == '0 && rd_off == '0, "R2 first beat", int'(rd_addr), 0);
        while (!fin && c < 2000) begin
            stall = stall_at(v, c);
            start = 1'b0;
            if (inject && k == 3 && !injected) begin
                injected = 1;
                start = 1'b1;   // R8: ignored mid-run
                cfg_til_step = 16'd1; cfg_til_lim = 16'd2;   // R9: ignored
                cfg_seq_step = 16'd1; cfg_seq_lim = 16'd2;
                cfg_aux_step = 16'd1; cfg_aux_lim = 16'd1;
            end
            if (prev_hold) begin
                chk(rd_valid && int'(rd_addr) == p_addr && int'(rd_off) == p_off,
                    "R6 stall hold", int'(rd_addr), p_addr);
            end
            prev_hold = rd_valid && stall;
            p_addr = int'(rd_addr);
            p_off = int'(rd_off);
            if (rd_valid) beat_cycles++;
            if (rd_valid && !stall) begin
                if (k < nexp) begin
                    chk(int'(rd_addr) == expv[k] / EPW, "R3 R8 R9 word address", int'(rd_addr), expv[k] / EPW);
                    chk(int'(rd_off) == expv[k] % EPW, "R4 offset", int'(rd_off), expv[k] % EPW);
                end
                k++;
            end
            if (done) begin
                fin = 1;
                chk(!rd_valid, "R7 valid low with done", int'(rd_valid), 0);
            end
            @(negedge clk);
            c++;
        end
        start = 1'b0;
        stall = 1'b0;
        chk(fin == 1, "R7 done seen", int'(fin), 1);
        chk(k == nexp, "R3 beat count", k, nexp);
        chk(!done && !rd_valid, "R7 done one cycle", int'(done), 0);
        if (v == 0 || v == 2)
            chk(beat_cycles == nexp, "R10 one beat per cycle", beat_cycles, nexp);
        if (v == 0)
            chk(k == 2 * 4, "R5 aligned beats", k, 8);
    endtask

    initial begin
        // R1: reset state.
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rd_valid && !done, "R1 reset state", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_valid && !done, "R1 idle after reset", int'(rd_valid), 0);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            run_vec(v, v == 3);
        end

        // R1: reset in the middle of a run.
        @(negedge clk);
        cfg_til_step = 16'd8; cfg_til_lim = 16'd16;
        cfg_seq_step = 16'd16; cfg_seq_lim = 16'd64;
        cfg_aux_step = 16'd8; cfg_aux_lim = 16'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!rd_valid && !done, "R1 reset mid-run", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: a fresh run after reset starts at zero again.
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rd_valid && rd_addr == '0 && rd_off == '0, "R2 restart at zero", int'(rd_addr), 0);
        repeat (12) @(negedge clk);
        chk(!rd_valid, "R7 run ended", int'(rd_valid), 0);

        finish_run();
    end
endmodule